// File: doc/BRIEF.md
# Serial Control Frame Receiver with Sync-Aligned Update

This block receives a fixed-length control frame on a three-wire serial link and presents it as thirteen parallel control bytes. A framing strobe frames each transfer. While the strobe is high, every rising edge of the serial clock shifts one data bit in. When the strobe drops, a frame of exactly 104 bits is staged in a shadow copy. Any other bit count is discarded and flagged.

Staged settings stay invisible until the next rising edge of a vertical-sync input. On that edge, the shadow copy moves into the active register that drives the outputs. Motor or video settings therefore change only on frame boundaries. All four serial and sync inputs are asynchronous to the system clock, and each is synchronised before use.

Top module: `ser_ctrl_frame`

## Requirements
- R1: While `rst_n` is low and after it is released, `ctrl_q` is all zero and `frame_err` is low. Reset also empties the staging, so no old frame can be applied later.
- R2: Bits are sent with the first byte first and each byte MSB first. After a 104-bit frame and a following `vsync` rise, the first serial bit appears at `ctrl_q[103]` and the last at `ctrl_q[0]`. Byte k (k=0 first sent) therefore sits on `ctrl_q[103-8k -: 8]`.
- R3: A received frame does not reach `ctrl_q` until a `vsync` rising edge. Between the `latch` fall and that edge, `ctrl_q` keeps its previous value.
- R4: Rising edges of `sclk` while `latch` is low shift nothing and do not count toward the frame length.
- R5: A frame with fewer than 104 bits is discarded and raises `frame_err` for exactly one clock cycle. A later `vsync` rise leaves `ctrl_q` unchanged.
- R6: A frame with more than 104 bits is discarded in the same way, with one single-cycle `frame_err` pulse.
- R7: A `vsync` rise with no valid frame pending leaves `ctrl_q` unchanged. Each valid frame is applied at most once.
- R8: If two valid frames arrive before a `vsync` rise, that rise applies the later one.
- R9: A reset between a valid frame and the `vsync` rise discards the staged frame, so `ctrl_q` stays zero after that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock; data sampled on its rising edge |
| sdata | input | 1 | Serial data bit |
| latch | input | 1 | Frame strobe; high while a frame is being sent |
| vsync | input | 1 | Vertical sync; a rising edge applies the staged frame |
| ctrl_q | output | 104 | Active control bytes, first byte in the top bits |
| frame_err | output | 1 | One-cycle pulse when a frame of the wrong length ends |

## Verification
The serial interface has no back-pressure: the block has no valid/ready stream, and frames are accepted at whatever rate the sender clocks them. Internal faults show up at the ports within a few cycles of the next strobe or sync edge.

A wrong bit count or a miscounted stray edge appears as a false or missing `frame_err` pulse about three cycles after `latch` falls. A bad pending flag or a bad shadow copy stays hidden until the next `vsync` rise. At that point `ctrl_q` takes a wrong value, or changes when it should hold.

The bench therefore follows every frame with a `vsync` pulse. It compares `ctrl_q` both before and after that pulse, so staging errors surface within one frame.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 13;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int SYNC_STAGES = 2;

  // Index of each synchronised input inside the sync vector.
  typedef enum int {
    IN_SCLK  = 0,
    IN_SDATA = 1,
    IN_LATCH = 2,
    IN_VSYNC = 3
  } sync_idx_e;
  localparam int NUM_IN = 4;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
  parameter int           W         = 3,
  parameter logic [W-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  // Each bit picks its rising or falling detector from the mask.
  for (genvar i = 0; i < W; i++) begin : g_edge
    if (FALL_MASK[i]) begin : g_fall
      assign edge_o[i] = prev[i] & ~lvl[i];
    end else begin : g_rise
      assign edge_o[i] = lvl[i] & ~prev[i];
    end
  end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int FRAME_BITS = 104,
  parameter int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  input  logic                  clr,
  output logic [FRAME_BITS-1:0] sreg,
  output logic [CNT_W-1:0]      cnt
);
  // One past the frame length marks "too many bits"; the count stops there.
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (clr) begin
      cnt  <= '0;
    end else if (bit_stb) begin
      sreg <= {sreg[FRAME_BITS-2:0], bit_val};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfr_stage.sv
module sfr_stage #(
  parameter int FRAME_BITS = 104
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  apply,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic [FRAME_BITS-1:0] active,
  output logic                  pend
);
  logic [FRAME_BITS-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      pend   <= 1'b0;
    end else begin
      if (apply && pend) active <= shadow;
      if (load) begin
        shadow <= frame_in;
        pend   <= 1'b1;
      end else if (apply) begin
        pend   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_ctrl_frame.sv
module ser_ctrl_frame
  import ser_frame_pkg::*;
#(
  parameter int BYTES  = FRAME_BYTES,
  parameter int BITS_B = BYTE_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      sdata,
  input  logic                      latch,
  input  logic                      vsync,
  output logic [BYTES*BITS_B-1:0]   ctrl_q,
  output logic                      frame_err
);
  localparam int NBITS = BYTES * BITS_B;
  localparam int CNT_W = $clog2(NBITS + 2);

  logic [NUM_IN-1:0] raw_in, syn_in;
  logic [2:0]        edges;
  logic              sclk_rise, latch_fall, vd_rise;
  logic              bit_stb, load, pend;
  logic [NBITS-1:0]  sreg;
  logic [CNT_W-1:0]  cnt;
  logic              len_ok;

  assign raw_in[IN_SCLK]  = sclk;
  assign raw_in[IN_SDATA] = sdata;
  assign raw_in[IN_LATCH] = latch;
  assign raw_in[IN_VSYNC] = vsync;

  sfr_sync #(.W(NUM_IN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  // edges: [0] sclk rise, [1] latch fall, [2] vsync rise
  sfr_edge #(.W(3), .FALL_MASK(3'b010)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({syn_in[IN_VSYNC], syn_in[IN_LATCH], syn_in[IN_SCLK]}),
    .edge_o(edges)
  );

  assign sclk_rise  = edges[0];
  assign latch_fall = edges[1];
  assign vd_rise    = edges[2];

  assign bit_stb = sclk_rise & syn_in[IN_LATCH];

  sfr_shifter #(.FRAME_BITS(NBITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(syn_in[IN_SDATA]), .clr(latch_fall),
    .sreg(sreg), .cnt(cnt)
  );

  assign len_ok = (cnt == CNT_W'(NBITS));
  assign load   = latch_fall & len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= latch_fall & ~len_ok;
  end

  sfr_stage #(.FRAME_BITS(NBITS)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .load(load), .apply(vd_rise), .frame_in(sreg),
    .active(ctrl_q), .pend(pend)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int NBITS = 104,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vd_rise,
  input logic             load,
  input logic             pend,
  input logic [CNT_W-1:0] cnt,
  input logic [NBITS-1:0] ctrl_q,
  input logic             frame_err
);
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_hold_until_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(vd_rise));

  p_no_pending_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_rise && !pend) |=> $stable(ctrl_q));

  p_pending_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_rise && pend && !load) |=> !pend);

  p_load_sets_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pend);

  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NBITS + 1));
endmodule

bind ser_ctrl_frame sfr_checker #(.NBITS(NBITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vd_rise(vd_rise), .load(load), .pend(pend),
  .cnt(cnt), .ctrl_q(ctrl_q), .frame_err(frame_err)
);

// File: tb/tb_ser_ctrl_frame.sv
module tb_ser_ctrl_frame;
  localparam int NB  = 104;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, latch = 1'b0, vsync = 1'b0;
  logic [NB-1:0] ctrl_q;
  logic frame_err;

  int checks = 0, errors = 0;
  int err_pulses = 0, run_len = 0, max_run = 0;
  logic [NB-1:0] exp_act = '0, exp_sh = '0;
  bit exp_pend = 0;

  ser_ctrl_frame dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
    .latch(latch), .vsync(vsync), .ctrl_q(ctrl_q), .frame_err(frame_err)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (frame_err) begin
      err_pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_vec(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] rand_frame();
    logic [NB-1:0] f;
    for (int i = 0; i < 4; i++) f[i*32 +: 32] = $urandom;
    f[103:96] = 8'($urandom);
    return f;
  endfunction

  // Sends nbits bits; bit i is d[NB-1-i] for i < NB, random beyond.
  task automatic send_frame(input int nbits, input logic [NB-1:0] d);
    latch = 1'b1;
    wait_n(GAP);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < NB) ? d[NB-1-i] : 1'($urandom);
      wait_n(GAP);
      sclk = 1'b1;
      wait_n(GAP);
      sclk = 1'b0;
      wait_n(GAP);
    end
    latch = 1'b0;
    wait_n(GAP);
    if (nbits == NB) begin
      exp_sh   = d;
      exp_pend = 1;
    end
  endtask

  task automatic pulse_vd();
    vsync = 1'b1;
    wait_n(GAP);
    vsync = 1'b0;
    wait_n(GAP);
    if (exp_pend) begin
      exp_act  = exp_sh;
      exp_pend = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(4);
    exp_act = '0; exp_sh = '0; exp_pend = 0;
    chk_vec("R1 during reset", ctrl_q, '0);
    chk_int("R1 frame_err in reset", int'(frame_err), 0);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    logic [NB-1:0] f, g;
    int e0;
    void'($urandom(32'h5EED_1234));
    do_reset();
    chk_vec("R1 after reset", ctrl_q, '0);

    // Directed byte-order frame: byte k holds value k+1
    for (int k = 0; k < 13; k++) f[NB-1-8*k -: 8] = 8'(k + 1);
    send_frame(NB, f);
    chk_vec("R3 held before sync", ctrl_q, exp_act);
    pulse_vd();
    chk_vec("R2 byte order", ctrl_q, f);
    chk_int("R2 first byte", int'(ctrl_q[103:96]), 1);
    chk_int("R2 last byte", int'(ctrl_q[7:0]), 13);

    // Random frames
    for (int n = 0; n < 5; n++) begin
      f = rand_frame();
      send_frame(NB, f);
      chk_vec("R3 random held", ctrl_q, exp_act);
      pulse_vd();
      chk_vec("R2 random applied", ctrl_q, f);
    end

    // R7: extra sync with nothing pending
    pulse_vd();
    chk_vec("R7 idle sync", ctrl_q, exp_act);

    // R5: short frame
    e0 = err_pulses;
    send_frame(NB - 1, rand_frame());
    chk_int("R5 short err pulse", err_pulses - e0, 1);
    chk_int("R5 pulse width", max_run, 1);
    pulse_vd();
    chk_vec("R5 short discarded", ctrl_q, exp_act);

    // R6: long frame
    e0 = err_pulses;
    send_frame(NB + 3, rand_frame());
    chk_int("R6 long err pulse", err_pulses - e0, 1);
    pulse_vd();
    chk_vec("R6 long discarded", ctrl_q, exp_act);

    // R4: stray sclk edges with latch low before a frame
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; wait_n(GAP); sclk = 1'b0; wait_n(GAP);
    end
    e0 = err_pulses;
    f = rand_frame();
    send_frame(NB, f);
    chk_int("R4 no err after strays", err_pulses - e0, 0);
    pulse_vd();
    chk_vec("R4 frame intact", ctrl_q, f);

    // R8: two frames before sync
    f = rand_frame();
    g = rand_frame();
    send_frame(NB, f);
    send_frame(NB, g);
    chk_vec("R8 held", ctrl_q, exp_act);
    pulse_vd();
    chk_vec("R8 latest applied", ctrl_q, g);

    // R9: reset between frame and sync
    send_frame(NB, rand_frame());
    do_reset();
    pulse_vd();
    chk_vec("R9 staged frame dropped", ctrl_q, '0);
    chk_int("R5 max pulse width overall", max_run, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule